// File: doc/BRIEF.md
# Memory-Management Control Register Bank

This block is the register file that a processor core reaches through its coprocessor move instructions to steer memory management. A write port carries a register number, a 3-bit secondary opcode (opcode_2), a 4-bit secondary register field (CRm) and a 32-bit value. A combinational read port returns the 32-bit view of the register named on the read address.

Three registers hold state: the main control word, the first-level translation table pointer and the per-domain access field word. Two further register numbers keep no state. A write to them becomes a one-cycle maintenance strobe: cache maintenance for any sub-code, and TLB maintenance for five recognised sub-codes only. The live control bits leave the block as separate outputs, so the MMU, caches, bus interface and exception logic read them directly.

Top module: `scc_regbank`

## Requirements
- R1: A write to register 1 updates the stored control bits at the next rising clock edge. The stored bits and their outputs are: bit 0 `mmu_en`, bit 1 `align_chk`, bit 2 `dcache_en`, bit 7 `big_endian` (1 = big), bit 8 `sys_prot`, bit 9 `rom_prot`, bit 12 `icache_en`, bit 13 vector select, bit 14 `rr_repl` (1 = round robin, 0 = random), bits 31:30 clocking mode.
- R2: A read of register 1 returns the stored bits at those positions. Bits 6:3 always read as 1111, and bits 11:10 and 29:15 always read as zero, whatever was written.
- R3: `vec_base` is 0x0000_0000 while control bit 13 is clear and 0xFFFF_0000 while it is set.
- R4: `clk_mode` mirrors control bits 31:30: 00 fast bus, 01 synchronous, 10 reserved, 11 asynchronous.
- R5: A write to register 2 stores data bits 31:14 as the table pointer and drops bits 13:0. Reads and `ttb_base` show bits 13:0 as zero.
- R6: Register 3 holds sixteen 2-bit domain fields that read back exactly as written. Field n sits at bits 2n+1:2n and drives `domain_ac`.
- R7: A write to register 4 changes no register and no output. Reads of registers 4, 7, 8 and of every unused register number return zero.
- R8: A write to register 7 raises `cache_op_vld` for exactly the one cycle after the write edge. At the same time `cache_op_code` = {opcode_2, CRm} and `cache_op_data` = the written word. This happens for every opcode_2/CRm pair.
- R9: A write to register 8 with a recognised pair raises `tlb_op_vld` for one cycle, carrying the written word on `tlb_op_addr`. The pairs (CRm, opcode_2) map to `tlb_op_kind` as follows: (7,0) gives 0, invalidate all of both TLBs. (5,0) gives 1, all instruction. (5,1) gives 2, one instruction entry. (6,0) gives 3, all data. (6,1) gives 4, one data entry.
- R10: A write to register 8 with any other opcode_2/CRm pair raises no TLB strobe.
- R11: While reset is asserted and after it releases: all control bits are zero, `vec_base` is 0, `ttb_base` and `domain_ac` are 0, both strobes are low, and a read of register 1 returns 0x0000_0078.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_crn | input | 4 | Register number for the write |
| wr_op2 | input | 3 | Secondary opcode of the write |
| wr_crm | input | 4 | Secondary register field of the write |
| wr_data | input | 32 | Write value |
| rd_crn | input | 4 | Register number for the read |
| rd_data | output | 32 | Read value (combinational) |
| mmu_en | output | 1 | MMU enable |
| align_chk | output | 1 | Alignment fault check enable |
| dcache_en | output | 1 | Data cache enable |
| icache_en | output | 1 | Instruction cache enable |
| big_endian | output | 1 | Big-endian operation |
| sys_prot | output | 1 | System protection bit |
| rom_prot | output | 1 | ROM protection bit |
| rr_repl | output | 1 | Round-robin replacement |
| vec_base | output | 32 | Exception vector base address |
| clk_mode | output | 2 | Clocking mode |
| ttb_base | output | 32 | Translation table base, low 14 bits zero |
| domain_ac | output | 32 | Sixteen 2-bit domain access fields |
| cache_op_vld | output | 1 | Cache maintenance strobe |
| cache_op_code | output | 7 | {opcode_2, CRm} of the cache operation |
| cache_op_data | output | 32 | Word written with the cache operation |
| tlb_op_vld | output | 1 | TLB maintenance strobe |
| tlb_op_kind | output | 3 | TLB operation kind, codes 0 to 4 |
| tlb_op_addr | output | 32 | Entry address written with the TLB operation |

## Verification
The control register is written with all ones, all zeros and a sparse mix. The all-ones write separates stored bits from forced-one and forced-zero bits. The all-zeros write shows that bits 6:3 are forced to one. The mix confirms that each output follows its own bit position. The table base takes a value with its low bits set, to expose the masking. The domain word takes an alternating pattern and is then probed after a register 4 write that must not disturb it. For maintenance, all five TLB pairs and an unrecognised one are driven, and a cache write with an arbitrary sub-code is driven. Each strobe is sampled in its one high cycle and again in the cycle after.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned CRN_W    = 4;
  localparam int unsigned OP2_W    = 3;
  localparam int unsigned CRM_W    = 4;
  localparam int unsigned CODE_W   = OP2_W + CRM_W;

  // register numbers
  localparam logic [CRN_W-1:0] RN_CTRL  = 4'd1;
  localparam logic [CRN_W-1:0] RN_TTB   = 4'd2;
  localparam logic [CRN_W-1:0] RN_DOM   = 4'd3;
  localparam logic [CRN_W-1:0] RN_RSVD  = 4'd4;
  localparam logic [CRN_W-1:0] RN_CACHE = 4'd7;
  localparam logic [CRN_W-1:0] RN_TLB   = 4'd8;

  // control word bit positions
  localparam int unsigned CB_MMU   = 0;
  localparam int unsigned CB_ALIGN = 1;
  localparam int unsigned CB_DC    = 2;
  localparam int unsigned CB_BIGE  = 7;
  localparam int unsigned CB_SYSP  = 8;
  localparam int unsigned CB_ROMP  = 9;
  localparam int unsigned CB_IC    = 12;
  localparam int unsigned CB_VHI   = 13;
  localparam int unsigned CB_RR    = 14;
  localparam int unsigned CB_CLKLO = 30;
  localparam int unsigned CB_CLKHI = 31;

  localparam logic [XLEN-1:0] CTRL_KEEP = 32'hC000_7387;
  localparam logic [XLEN-1:0] CTRL_ONES = 32'h0000_0078;
  localparam logic [XLEN-1:0] VEC_HIGH  = 32'hFFFF_0000;

  typedef enum logic [2:0] {
    TLB_ALL_BOTH = 3'd0,
    TLB_ALL_I    = 3'd1,
    TLB_ENT_I    = 3'd2,
    TLB_ALL_D    = 3'd3,
    TLB_ENT_D    = 3'd4
  } tlb_kind_e;

  typedef struct packed {
    logic      hit;
    tlb_kind_e kind;
  } tlb_dec_t;

  // read view of the control word: stored bits plus hard-wired fields
  function automatic logic [XLEN-1:0] ctrl_view(input logic [XLEN-1:0] stored);
    return (stored & CTRL_KEEP) | CTRL_ONES;
  endfunction

  function automatic logic [XLEN-1:0] vec_of(input logic hi);
    return hi ? VEC_HIGH : '0;
  endfunction

  function automatic tlb_dec_t tlb_decode(input logic [OP2_W-1:0] op2,
                                          input logic [CRM_W-1:0] crm);
    tlb_dec_t d;
    d.hit  = 1'b1;
    d.kind = TLB_ALL_BOTH;
    unique case ({crm, op2})
      {4'd7, 3'd0}: d.kind = TLB_ALL_BOTH;
      {4'd5, 3'd0}: d.kind = TLB_ALL_I;
      {4'd5, 3'd1}: d.kind = TLB_ENT_I;
      {4'd6, 3'd0}: d.kind = TLB_ALL_D;
      {4'd6, 3'd1}: d.kind = TLB_ENT_D;
      default:      d.hit  = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/scc_ctrl_reg.sv
module scc_ctrl_reg
  import scc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stored
);
  localparam logic [W-1:0] KEEP = W'(CTRL_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stored <= '0;
    else if (we) stored <= wdata & KEEP;
  end
endmodule

// File: rtl/scc_tbl_regs.sv
module scc_tbl_regs #(
  parameter int unsigned W       = 32,
  parameter int unsigned TTB_LSB = 14,
  parameter int unsigned DOM_N   = 16,
  parameter int unsigned DOM_W   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_ttb,
  input  logic         we_dom,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ttb,
  output logic [W-1:0] dom
);
  localparam int unsigned PTR_W = W - TTB_LSB;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (we_ttb) ptr_q <= wdata[W-1:TTB_LSB];
  end
  assign ttb = {ptr_q, {TTB_LSB{1'b0}}};

  for (genvar g = 0; g < DOM_N; g++) begin : g_dom
    logic [DOM_W-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q <= '0;
      else if (we_dom) fld_q <= wdata[g*DOM_W +: DOM_W];
    end
    assign dom[g*DOM_W +: DOM_W] = fld_q;
  end
endmodule

// File: rtl/scc_maint_dec.sv
module scc_maint_dec
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_wr,
  input  logic              tlb_wr,
  input  logic [OP2_W-1:0]  op2,
  input  logic [CRM_W-1:0]  crm,
  input  logic [XLEN-1:0]   data,
  output logic              tlb_hit,
  output logic              cache_vld,
  output logic [CODE_W-1:0] cache_code,
  output logic [XLEN-1:0]   cache_data,
  output logic              tlb_vld,
  output tlb_kind_e         tlb_kind,
  output logic [XLEN-1:0]   tlb_addr
);
  tlb_dec_t dec;
  assign dec     = tlb_decode(op2, crm);
  assign tlb_hit = dec.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_vld  <= 1'b0;
      cache_code <= '0;
      cache_data <= '0;
      tlb_vld    <= 1'b0;
      tlb_kind   <= TLB_ALL_BOTH;
      tlb_addr   <= '0;
    end else begin
      cache_vld <= cache_wr;
      tlb_vld   <= tlb_wr && dec.hit;
      if (cache_wr) begin
        cache_code <= {op2, crm};
        cache_data <= data;
      end
      if (tlb_wr && dec.hit) begin
        tlb_kind <= dec.kind;
        tlb_addr <= data;
      end
    end
  end
endmodule

// File: rtl/scc_regbank.sv
module scc_regbank
  import scc_pkg::*;
#(
  parameter int unsigned TTB_LSB = 14,
  parameter int unsigned DOM_N   = 16,
  parameter int unsigned DOM_W   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_crn,
  input  logic [2:0]   wr_op2,
  input  logic [3:0]   wr_crm,
  input  logic [31:0]  wr_data,
  input  logic [3:0]   rd_crn,
  output logic [31:0]  rd_data,
  output logic         mmu_en,
  output logic         align_chk,
  output logic         dcache_en,
  output logic         icache_en,
  output logic         big_endian,
  output logic         sys_prot,
  output logic         rom_prot,
  output logic         rr_repl,
  output logic [31:0]  vec_base,
  output logic [1:0]   clk_mode,
  output logic [31:0]  ttb_base,
  output logic [31:0]  domain_ac,
  output logic         cache_op_vld,
  output logic [6:0]   cache_op_code,
  output logic [31:0]  cache_op_data,
  output logic         tlb_op_vld,
  output logic [2:0]   tlb_op_kind,
  output logic [31:0]  tlb_op_addr
);
  // named write events, also watched by the checker
  logic wr_ctrl, wr_ttb, wr_dom, wr_cache, wr_tlb, tlb_hit;
  assign wr_ctrl  = wr_en && (wr_crn == RN_CTRL);
  assign wr_ttb   = wr_en && (wr_crn == RN_TTB);
  assign wr_dom   = wr_en && (wr_crn == RN_DOM);
  assign wr_cache = wr_en && (wr_crn == RN_CACHE);
  assign wr_tlb   = wr_en && (wr_crn == RN_TLB);

  logic [XLEN-1:0] ctrl_q;
  tlb_kind_e       kind_w;

  scc_ctrl_reg #(.W(XLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(wr_ctrl), .wdata(wr_data), .stored(ctrl_q)
  );

  scc_tbl_regs #(.W(XLEN), .TTB_LSB(TTB_LSB), .DOM_N(DOM_N), .DOM_W(DOM_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we_ttb(wr_ttb), .we_dom(wr_dom),
    .wdata(wr_data), .ttb(ttb_base), .dom(domain_ac)
  );

  scc_maint_dec u_maint (
    .clk(clk), .rst_n(rst_n), .cache_wr(wr_cache), .tlb_wr(wr_tlb),
    .op2(wr_op2), .crm(wr_crm), .data(wr_data), .tlb_hit(tlb_hit),
    .cache_vld(cache_op_vld), .cache_code(cache_op_code), .cache_data(cache_op_data),
    .tlb_vld(tlb_op_vld), .tlb_kind(kind_w), .tlb_addr(tlb_op_addr)
  );
  assign tlb_op_kind = kind_w;

  assign mmu_en     = ctrl_q[CB_MMU];
  assign align_chk  = ctrl_q[CB_ALIGN];
  assign dcache_en  = ctrl_q[CB_DC];
  assign big_endian = ctrl_q[CB_BIGE];
  assign sys_prot   = ctrl_q[CB_SYSP];
  assign rom_prot   = ctrl_q[CB_ROMP];
  assign icache_en  = ctrl_q[CB_IC];
  assign rr_repl    = ctrl_q[CB_RR];
  assign clk_mode   = ctrl_q[CB_CLKHI:CB_CLKLO];
  assign vec_base   = vec_of(ctrl_q[CB_VHI]);

  always_comb begin
    unique case (rd_crn)
      RN_CTRL: rd_data = ctrl_view(ctrl_q);
      RN_TTB:  rd_data = ttb_base;
      RN_DOM:  rd_data = domain_ac;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/scc_regbank_chk.sv
module scc_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_crn,
  input logic [3:0]  rd_crn,
  input logic [31:0] rd_data,
  input logic [31:0] vec_base,
  input logic [31:0] ttb_base,
  input logic [31:0] domain_ac,
  input logic [1:0]  clk_mode,
  input logic        mmu_en,
  input logic        cache_op_vld,
  input logic        tlb_op_vld,
  input logic [2:0]  tlb_op_kind,
  input logic        wr_cache,
  input logic        wr_tlb,
  input logic        tlb_hit
);
  // R2
  ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_crn == 4'd1) |-> (rd_data[6:3] == 4'hF && rd_data[11:10] == 2'b00 && rd_data[29:15] == '0));
  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_base == 32'h0) || (vec_base == 32'hFFFF_0000));
  // R5
  ttb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ttb_base[13:0] == 14'h0);
  // R7
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_crn == 4'd4) |=> ($stable(ttb_base) && $stable(domain_ac) && $stable(clk_mode) && $stable(mmu_en)));
  // R7
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_crn == 4'd4 || rd_crn == 4'd7 || rd_crn == 4'd8) |-> (rd_data == '0));
  // R8
  cache_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cache |=> cache_op_vld);
  // R8
  cache_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cache |=> !cache_op_vld);
  // R9
  tlb_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_op_vld |-> (tlb_op_kind <= 3'd4));
  // R9
  tlb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tlb && tlb_hit) |=> tlb_op_vld);
  // R10
  tlb_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_tlb && tlb_hit) |=> !tlb_op_vld);
endmodule

bind scc_regbank scc_regbank_chk u_chk (.*);

// File: tb/tb_scc_regbank.sv
module tb_scc_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_crn = '0;
  logic [2:0]  wr_op2 = '0;
  logic [3:0]  wr_crm = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_crn = '0;
  logic [31:0] rd_data, vec_base, ttb_base, domain_ac, cache_op_data, tlb_op_addr;
  logic        mmu_en, align_chk, dcache_en, icache_en, big_endian, sys_prot, rom_prot, rr_repl;
  logic [1:0]  clk_mode;
  logic        cache_op_vld, tlb_op_vld;
  logic [6:0]  cache_op_code;
  logic [2:0]  tlb_op_kind;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scc_regbank dut (.*);

  typedef struct packed {
    logic [3:0]  crn;
    logic [2:0]  op2;
    logic [3:0]  crm;
    logic [31:0] wd;
    logic [3:0]  rcrn;
    logic [31:0] exp;
  } vec_t;

  // write, then read back the given register
  localparam vec_t VEC [0:7] = '{
    '{4'd1, 3'd0, 4'd0, 32'hFFFF_FFFF, 4'd1, 32'hC000_73FF},  // R1 R2 all ones
    '{4'd1, 3'd0, 4'd0, 32'h0000_0000, 4'd1, 32'h0000_0078},  // R2 forced ones
    '{4'd1, 3'd0, 4'd0, 32'h0000_2085, 4'd1, 32'h0000_20FD},  // R1 sparse mix
    '{4'd2, 3'd0, 4'd0, 32'h1234_5FFF, 4'd2, 32'h1234_4000},  // R5 masking
    '{4'd3, 3'd0, 4'd0, 32'hA5A5_0F0F, 4'd3, 32'hA5A5_0F0F},  // R6 domains
    '{4'd4, 3'd0, 4'd0, 32'hFFFF_FFFF, 4'd3, 32'hA5A5_0F0F},  // R7 reserved write
    '{4'd8, 3'd0, 4'd7, 32'h5555_AAAA, 4'd8, 32'h0000_0000},  // R7 tlb reads zero
    '{4'd7, 3'd0, 4'd5, 32'h3333_CCCC, 4'd7, 32'h0000_0000}   // R7 cache reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] crn, input logic [2:0] op2,
                          input logic [3:0] crm, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_crn = crn; wr_op2 = op2; wr_crm = crm; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tlb_case(input logic [2:0] op2, input logic [3:0] crm,
                          input logic [2:0] kind, input logic [31:0] a);
    do_write(4'd8, op2, crm, a);
    #1;
    chk("R9 tlb vld", {31'b0, tlb_op_vld}, 32'd1);
    chk("R9 tlb kind", {29'b0, tlb_op_kind}, {29'b0, kind});
    chk("R9 tlb addr", tlb_op_addr, a);
    @(negedge clk); #1;
    chk("R9 tlb one cycle", {31'b0, tlb_op_vld}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    rd_crn = 4'd1; #1;
    chk("R11 ctrl read in reset", rd_data, 32'h0000_0078);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 ctrl read", rd_data, 32'h0000_0078);
    chk("R11 control outs", {24'b0, mmu_en, align_chk, dcache_en, icache_en,
                             big_endian, sys_prot, rom_prot, rr_repl}, 32'd0);
    chk("R11 vec_base", vec_base, 32'h0);
    chk("R11 ttb", ttb_base, 32'h0);
    chk("R11 domain", domain_ac, 32'h0);
    chk("R11 strobes", {30'b0, cache_op_vld, tlb_op_vld}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i].crn, VEC[i].op2, VEC[i].crm, VEC[i].wd);
      rd_crn = VEC[i].rcrn; #1;
      chk($sformatf("R1/R2/R5/R6/R7 vector %0d", i), rd_data, VEC[i].exp);
      if (i == 2) begin
        // R1 R3 outputs after 0x2085
        chk("R1 outs", {24'b0, mmu_en, align_chk, dcache_en, icache_en,
                        big_endian, sys_prot, rom_prot, rr_repl}, 32'b1010_1000);
        chk("R3 vec high", vec_base, 32'hFFFF_0000);
      end
      if (i == 5) begin
        rd_crn = 4'd2; #1;
        chk("R7 ttb untouched", rd_data, 32'h1234_4000);
        rd_crn = 4'd4; #1;
        chk("R7 reserved reads zero", rd_data, 32'h0);
        chk("R7 ctrl outs untouched", {30'b0, clk_mode}, 32'd0);
      end
    end
    rd_crn = 4'd0; #1;
    chk("R7 unused reads zero", rd_data, 32'h0);
    rd_crn = 4'd2; #1;
    chk("R5 ttb_base port", ttb_base, 32'h1234_4000);
    chk("R6 domain_ac port", domain_ac, 32'hA5A5_0F0F);

    // R4 clocking modes, R3 low vector
    do_write(4'd1, 3'd0, 4'd0, 32'h4000_0000); #1;
    chk("R4 synchronous", {30'b0, clk_mode}, 32'd1);
    chk("R3 vec low", vec_base, 32'h0);
    do_write(4'd1, 3'd0, 4'd0, 32'h8000_0000); #1;
    chk("R4 reserved", {30'b0, clk_mode}, 32'd2);
    do_write(4'd1, 3'd0, 4'd0, 32'hC000_4000); #1;
    chk("R4 asynchronous", {30'b0, clk_mode}, 32'd3);
    chk("R1 round robin", {31'b0, rr_repl}, 32'd1);

    // R8 cache strobe
    do_write(4'd7, 3'd1, 4'd10, 32'hCAFE_0001); #1;
    chk("R8 cache vld", {31'b0, cache_op_vld}, 32'd1);
    chk("R8 cache code", {25'b0, cache_op_code}, 32'h1A);
    chk("R8 cache data", cache_op_data, 32'hCAFE_0001);
    @(negedge clk); #1;
    chk("R8 cache one cycle", {31'b0, cache_op_vld}, 32'd0);

    // R9 all five TLB operations
    tlb_case(3'd0, 4'd7, 3'd0, 32'h0000_1000);
    tlb_case(3'd0, 4'd5, 3'd1, 32'h0000_2000);
    tlb_case(3'd1, 4'd5, 3'd2, 32'hDEAD_0000);
    tlb_case(3'd0, 4'd6, 3'd3, 32'h0000_4000);
    tlb_case(3'd1, 4'd6, 3'd4, 32'hBEEF_0000);

    // R10 unrecognised pairs
    do_write(4'd8, 3'd0, 4'd4, 32'h1111_1111); #1;
    chk("R10 no strobe crm4", {31'b0, tlb_op_vld}, 32'd0);
    do_write(4'd8, 3'd2, 4'd7, 32'h2222_2222); #1;
    chk("R10 no strobe op2=2", {31'b0, tlb_op_vld}, 32'd0);
    chk("R10 addr held", tlb_op_addr, 32'hBEEF_0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule